// File: doc/BRIEF.md
# Masked Interrupt Pulse Generator

This block turns a set of seven event strobes into timed, active-high interrupt pulses on a small number of output pins (two by default). Each strobe sets a sticky flag that stays set until the host acknowledges a read of the flags. Every output pin has its own 8-bit control register. Bits 7..1 of that register form a per-source enable mask, and bit 0 selects how the pin behaves. With bit 0 clear, the pin gives one pulse for each enabled event. With bit 0 set, the pin repeats its pulse while any enabled flag is still set.

Pulse timing comes from a millisecond tick input. A pulse always begins on a tick and lasts exactly two tick intervals. In repeat mode the pulses occur every four tick intervals. Changes to the mode and the mask are sampled only at pulse boundaries, so a pulse that has started always runs to its full length. All output pins see the same event strobes and the same acknowledge.

Top module: `irq_pulse_gen`

## Requirements
- R1: After reset every control register is 0: all sources are masked, single mode is selected and every irq bit is low. While the registers stay 0, no event strobe produces a pulse.
- R2: Strobe bit i (0..6) can cause a pulse on an output only when bit i+1 of that output's control register is 1. Strobes on masked sources produce no pulse.
- R3: A pulse rises only in the cycle after a clock edge at which ms_tick was high.
- R4: Every pulse is high for exactly HIGH_TICKS tick intervals (2 by default).
- R5: In single mode (control bit 0 = 0), each enabled strobe gives one pulse. Strobes that arrive while a pulse or its following low phase is in progress merge into one further pulse. That pulse starts PERIOD_TICKS ticks after the previous rise.
- R6: In repeat mode (control bit 0 = 1), pulses rise every PERIOD_TICKS ticks (4 by default) for as long as any enabled sticky flag is set.
- R7: A flag_ack pulse clears all sticky flags. A repeat train then stops at its next boundary. A pulse already in progress is never cut short.
- R8: A strobe that arrives in the same cycle as flag_ack leaves its flag set.
- R9: A write to the mode or mask while a pulse is active does not change that pulse. The new setting applies from the next boundary onward.
- R10: ctrl_sel chooses which output's register a write goes to (0 selects irq[0], 1 selects irq[1]). Registers that are not selected keep their value. All outputs share the same event strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_sel | input | SEL_W | Selects the output whose register is written |
| ctrl_wdata | input | 8 | Write data: bits 7..1 mask, bit 0 repeat mode |
| evt_strobe | input | 7 | One-cycle event strobes, one per source |
| flag_ack | input | 1 | Flag-read acknowledge; clears all sticky flags |
| ms_tick | input | 1 | One-cycle time-base tick |
| irq | output | NUM_OUT | Interrupt pulse outputs |

## Verification
The bench uses the default parameters: two outputs, a high time of two ticks and a period of four ticks. It drives a tick every five clocks, so a pulse is 10 cycles wide and a repeat period is 20 cycles. At this scale, multi-pulse trains, acknowledges placed in the high phase or in the low phase, and writes to mode and mask in the middle of a pulse all complete within a few hundred cycles. The bench also uses both outputs, which lets it check that the two register selections and the shared event inputs are handled correctly.

// File: rtl/irqp_pkg.sv
package irqp_pkg;

    localparam int SRC_COUNT = 7;
    localparam int CTRL_W    = SRC_COUNT + 1;

    // Control word: mask in the upper bits (source i at bit i+1), mode in bit 0
    typedef struct packed {
        logic [SRC_COUNT-1:0] mask;
        logic                 repeat_en;
    } ctrl_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HIGH = 2'd1,
        PH_LOW  = 2'd2
    } phase_e;

    function automatic logic any_enabled(input logic [SRC_COUNT-1:0] bits,
                                         input logic [SRC_COUNT-1:0] mask);
        return |(bits & mask);
    endfunction

endpackage

// File: rtl/irqp_flags.sv
module irqp_flags
    import irqp_pkg::*;
(
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic [SRC_COUNT-1:0] evt_i,
    input  logic                 ack_i,
    output logic [SRC_COUNT-1:0] flags_o
);

    logic [SRC_COUNT-1:0] flags_q;

    // a new event in the acknowledge cycle stays set
    always_ff @(posedge clk_i) begin
        if (rst_i) flags_q <= '0;
        else       flags_q <= (ack_i ? '0 : flags_q) | evt_i;
    end

    assign flags_o = flags_q;

    assert_ack_clears_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (ack_i && evt_i == '0) |=> flags_o == '0);

    assert_event_sticks_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (evt_i != '0) |=> ((flags_o & $past(evt_i)) == $past(evt_i)));

endmodule

// File: rtl/irqp_ctrl_reg.sv
module irqp_ctrl_reg
    import irqp_pkg::*;
#(
    parameter int SEL_W  = 1,
    parameter int MY_SEL = 0
)
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_en_i,
    input  logic [SEL_W-1:0]  wr_sel_i,
    input  logic [CTRL_W-1:0] wr_data_i,
    output ctrl_t             ctrl_o
);

    localparam logic [SEL_W-1:0] SEL_CODE = SEL_W'(MY_SEL);

    ctrl_t ctrl_q;
    logic  hit_w;

    assign hit_w = wr_en_i && (wr_sel_i == SEL_CODE);

    always_ff @(posedge clk_i) begin
        if (rst_i)      ctrl_q <= '0;
        else if (hit_w) ctrl_q <= ctrl_t'(wr_data_i);
    end

    assign ctrl_o = ctrl_q;

    assert_unselected_holds_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        !(wr_en_i && wr_sel_i == SEL_CODE) |=> $stable(ctrl_o));

    assert_reset_value_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(rst_i) |-> ctrl_o == '0);

endmodule

// File: rtl/irqp_pulse.sv
module irqp_pulse
    import irqp_pkg::*;
#(
    parameter int HIGH_TICKS   = 2,
    parameter int PERIOD_TICKS = 4
)
(
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic                 tick_i,
    input  ctrl_t                ctrl_i,
    input  logic [SRC_COUNT-1:0] evt_i,
    input  logic [SRC_COUNT-1:0] flags_i,
    output logic                 irq_o
);

    localparam int LOW_TICKS = PERIOD_TICKS - HIGH_TICKS;
    localparam int CNT_W     = (PERIOD_TICKS > 1) ? $clog2(PERIOD_TICKS) : 1;
    localparam logic [CNT_W-1:0] HIGH_LAST = CNT_W'(HIGH_TICKS - 1);
    localparam logic [CNT_W-1:0] LOW_LAST  = CNT_W'(LOW_TICKS - 1);

    phase_e           phase_q, phase_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             pend_q, pend_d;
    logic             trig_w, req_w, boundary_w, start_w;

    // single mode remembers one enabled strobe; repeat mode follows the flags
    assign trig_w     = any_enabled(evt_i, ctrl_i.mask);
    assign req_w      = ctrl_i.repeat_en ? any_enabled(flags_i, ctrl_i.mask) : pend_q;
    assign boundary_w = tick_i && ((phase_q == PH_IDLE) ||
                                   (phase_q == PH_LOW && cnt_q == LOW_LAST));
    assign start_w    = boundary_w && req_w;
    assign pend_d     = (pend_q && !start_w) || trig_w;

    always_comb begin
        phase_d = phase_q;
        cnt_d   = cnt_q;
        if (start_w) begin
            phase_d = PH_HIGH;
            cnt_d   = '0;
        end else if (tick_i) begin
            case (phase_q)
                PH_HIGH: begin
                    if (cnt_q == HIGH_LAST) begin
                        phase_d = PH_LOW;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                PH_LOW: begin
                    if (cnt_q == LOW_LAST) begin
                        phase_d = PH_IDLE;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            pend_q  <= 1'b0;
        end else begin
            phase_q <= phase_d;
            cnt_q   <= cnt_d;
            pend_q  <= pend_d;
        end
    end

    assign irq_o = (phase_q == PH_HIGH);

    assert_rise_on_tick_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(irq_o) |-> $past(tick_i));

    assert_fall_on_tick_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(irq_o) |-> $past(tick_i));

    assert_high_count_bound_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (phase_q == PH_HIGH) |-> (int'(cnt_q) < HIGH_TICKS));

    assert_low_count_bound_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (phase_q == PH_LOW) |-> (int'(cnt_q) < LOW_TICKS));

endmodule

// File: rtl/irq_pulse_gen.sv
module irq_pulse_gen
    import irqp_pkg::*;
#(
    parameter int NUM_OUT      = 2,
    parameter int HIGH_TICKS   = 2,
    parameter int PERIOD_TICKS = 4,
    localparam int SEL_W       = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1
)
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ctrl_we,
    input  logic [SEL_W-1:0]     ctrl_sel,
    input  logic [CTRL_W-1:0]    ctrl_wdata,
    input  logic [SRC_COUNT-1:0] evt_strobe,
    input  logic                 flag_ack,
    input  logic                 ms_tick,
    output logic [NUM_OUT-1:0]   irq
);

    logic [SRC_COUNT-1:0] flags_w;

    irqp_flags u_flags (
        .clk_i   (clk),
        .rst_i   (rst),
        .evt_i   (evt_strobe),
        .ack_i   (flag_ack),
        .flags_o (flags_w)
    );

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
        ctrl_t ctrl_w;

        irqp_ctrl_reg #(
            .SEL_W  (SEL_W),
            .MY_SEL (g)
        ) u_ctrl (
            .clk_i     (clk),
            .rst_i     (rst),
            .wr_en_i   (ctrl_we),
            .wr_sel_i  (ctrl_sel),
            .wr_data_i (ctrl_wdata),
            .ctrl_o    (ctrl_w)
        );

        irqp_pulse #(
            .HIGH_TICKS   (HIGH_TICKS),
            .PERIOD_TICKS (PERIOD_TICKS)
        ) u_pulse (
            .clk_i   (clk),
            .rst_i   (rst),
            .tick_i  (ms_tick),
            .ctrl_i  (ctrl_w),
            .evt_i   (evt_strobe),
            .flags_i (flags_w),
            .irq_o   (irq[g])
        );
    end

endmodule

// File: tb/irq_pulse_gen_tb.sv
`timescale 1ns/1ps
module irq_pulse_gen_tb;

    localparam int TICK_DIV = 5;
    localparam int WIDTH_CY = 2 * TICK_DIV;
    localparam int GAP_CY   = 4 * TICK_DIV;

    typedef struct {
        int    width;
        int    gap;
        string tag;
    } item_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ctrl_we = 1'b0;
    logic [0:0] ctrl_sel = '0;
    logic [7:0] ctrl_wdata = '0;
    logic [6:0] evt_strobe = '0;
    logic       flag_ack = 1'b0;
    logic       ms_tick = 1'b0;
    logic [1:0] irq;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int tdiv = 0;
    logic last_tick = 1'b0;
    item_t q0[$];
    item_t q1[$];
    logic [1:0] prev_irq = '0;
    int rise_at[2];
    int prev_rise[2];

    irq_pulse_gen u_dut (
        .clk        (clk),
        .rst        (rst),
        .ctrl_we    (ctrl_we),
        .ctrl_sel   (ctrl_sel),
        .ctrl_wdata (ctrl_wdata),
        .evt_strobe (evt_strobe),
        .flag_ack   (flag_ack),
        .ms_tick    (ms_tick),
        .irq        (irq)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cyc       <= cyc + 1;
        last_tick <= ms_tick;
    end

    always @(negedge clk) begin
        tdiv    = (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
        ms_tick = (tdiv == TICK_DIV - 1);
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic expect_pulse(input int o, input int gap, input string tag);
        item_t it;
        it.width = WIDTH_CY;
        it.gap   = gap;
        it.tag   = tag;
        if (o == 0) q0.push_back(it);
        else        q1.push_back(it);
    endtask

    task automatic pop_compare(input int o, input int width, input int gap);
        item_t it;
        bit    have;
        have = (o == 0) ? (q0.size() != 0) : (q1.size() != 0);
        if (!have) begin
            chk(1'b0, "R2", $sformatf("unexpected pulse on irq[%0d]", o), 1, 0);
        end else begin
            it = (o == 0) ? q0.pop_front() : q1.pop_front();
            chk(width == it.width, "R4", $sformatf("%s width irq[%0d]", it.tag, o),
                width, it.width);
            if (it.gap != 0)
                chk(gap == it.gap, it.tag, $sformatf("rise spacing irq[%0d]", o),
                    gap, it.gap);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            for (int o = 0; o < 2; o++) begin
                if (irq[o] && !prev_irq[o]) begin
                    chk(last_tick == 1'b1, "R3", "rise without tick", 0, 1);
                    prev_rise[o] = rise_at[o];
                    rise_at[o]   = cyc;
                end
                if (!irq[o] && prev_irq[o])
                    pop_compare(o, cyc - rise_at[o], rise_at[o] - prev_rise[o]);
                prev_irq[o] = irq[o];
            end
        end
    end

    task automatic wr_ctrl(input int sel, input logic [7:0] data);
        @(negedge clk);
        ctrl_we    = 1'b1;
        ctrl_sel   = sel[0:0];
        ctrl_wdata = data;
        @(negedge clk);
        ctrl_we    = 1'b0;
    endtask

    task automatic pulse_in(input logic [6:0] evt, input logic ack);
        @(negedge clk);
        evt_strobe = evt;
        flag_ack   = ack;
        @(negedge clk);
        evt_strobe = '0;
        flag_ack   = 1'b0;
    endtask

    task automatic wait_rise(input int o);
        @(negedge clk);
        while (!irq[o]) @(negedge clk);
    endtask

    task automatic drain(input string tag);
        repeat (80) @(negedge clk);
        chk(q0.size() == 0, tag, "missing pulses irq[0]", q0.size(), 0);
        chk(q1.size() == 0, tag, "missing pulses irq[1]", q1.size(), 0);
        chk(irq == 2'b00, tag, "irq idle after sequence", int'(irq), 0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        chk(1'b0, "watchdog", "run did not finish", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        rise_at   = '{0, 0};
        prev_rise = '{0, 0};
        repeat (4) @(negedge clk);
        chk(irq == 2'b00, "R1", "irq during reset", int'(irq), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(irq == 2'b00, "R1", "irq after reset", int'(irq), 0);

        // R1: reset masks everything
        pulse_in(7'h7F, 1'b0);
        drain("R1");
        pulse_in(7'h00, 1'b1);

        // R2 / R10: only source 6 enabled on irq[0]
        wr_ctrl(0, 8'h80);
        pulse_in(7'h3F, 1'b0);
        drain("R2");
        pulse_in(7'h00, 1'b1);
        expect_pulse(0, 0, "R2");
        pulse_in(7'h40, 1'b0);
        drain("R10");
        pulse_in(7'h00, 1'b1);

        // R5: two strobes during a pulse merge into one more pulse
        expect_pulse(0, 0, "R5");
        expect_pulse(0, GAP_CY, "R5");
        pulse_in(7'h40, 1'b0);
        wait_rise(0);
        repeat (3) @(negedge clk);
        pulse_in(7'h40, 1'b0);
        pulse_in(7'h40, 1'b0);
        drain("R5");
        pulse_in(7'h00, 1'b1);

        // R6 / R7: repeat train on irq[1], ack in the third low phase
        wr_ctrl(0, 8'h00);
        wr_ctrl(1, 8'h03);
        expect_pulse(1, 0, "R6");
        expect_pulse(1, GAP_CY, "R6");
        expect_pulse(1, GAP_CY, "R6");
        pulse_in(7'h01, 1'b0);
        wait_rise(1);
        repeat (50) @(negedge clk);
        pulse_in(7'h00, 1'b1);
        drain("R7");

        // R7: ack during the high phase does not cut the pulse
        expect_pulse(1, 0, "R7");
        pulse_in(7'h01, 1'b0);
        wait_rise(1);
        repeat (2) @(negedge clk);
        pulse_in(7'h00, 1'b1);
        drain("R7");

        // R8: ack together with a new strobe keeps the train alive
        expect_pulse(1, 0, "R8");
        expect_pulse(1, GAP_CY, "R8");
        pulse_in(7'h01, 1'b0);
        wait_rise(1);
        repeat (13) @(negedge clk);
        pulse_in(7'h01, 1'b1);
        repeat (17) @(negedge clk);
        pulse_in(7'h00, 1'b1);
        drain("R8");

        // R9: switch to single mode in the middle of a pulse
        expect_pulse(1, 0, "R9");
        pulse_in(7'h01, 1'b0);
        wait_rise(1);
        repeat (3) @(negedge clk);
        wr_ctrl(1, 8'h02);
        drain("R9");
        pulse_in(7'h00, 1'b1);

        // R9: clear the mask in the middle of a pulse
        wr_ctrl(0, 8'h80);
        expect_pulse(0, 0, "R9");
        pulse_in(7'h40, 1'b0);
        wait_rise(0);
        repeat (2) @(negedge clk);
        wr_ctrl(0, 8'h00);
        drain("R9");
        pulse_in(7'h00, 1'b1);

        // R10: shared source on both outputs, then a source enabled on one only
        wr_ctrl(0, 8'h10);
        wr_ctrl(1, 8'h10);
        expect_pulse(0, 0, "R10");
        expect_pulse(1, 0, "R10");
        pulse_in(7'h08, 1'b0);
        drain("R10");
        wr_ctrl(1, 8'h04);
        expect_pulse(1, 0, "R10");
        pulse_in(7'h02, 1'b0);
        drain("R10");
        pulse_in(7'h00, 1'b1);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule